// File: doc/BRIEF.md
# Regulator Fault Supervisor With Latch

This block is the digital supervisor beside a dual-output supply controller: one switching stage with a high-side and a low-side switch, and one linear pass device. It takes the flags of the analog comparators and an external enable. It grants the gate-enable signals only when the supply is healthy, the enable is high and no fault has been recorded. The comparator flags and the enable come from outside the clock domain, so each one passes through a two-flop synchronizer before any logic uses it.

Supply health uses hysteresis. The rising-threshold flag starts operation, and only the falling-threshold flag stops it. Three conditions count as faults:

- overcurrent on the low-side switch;
- undervoltage on the switching feedback;
- undervoltage on the linear feedback.

Any fault shuts down all three outputs, whichever channel it came from, and is latched together with a 2-bit code. Each undervoltage flag is ignored until the soft-start done flag of its own channel is set. Toggling the enable does not clear a latched fault. Only a supply drop, seen as the falling-threshold flag, clears it. A `ss_run_o` output tells the soft-start sequencer when to ramp, so that releasing the enable restarts the outputs through soft-start.

Top module: `reg_fault_supervisor`

## Requirements
- R1: A change on a comparator flag or on the enable reaches the gate outputs on the second rising clock edge after it is applied, not on the first.
- R2: After reset, all gate enables stay low until the rising-supply flag has been seen. Once set, supply-good stays set after the rising flag drops, and only the falling-supply flag clears it.
- R3: With the enable low, `hs_en_o`, `ls_en_o`, `lin_en_o` and `ss_run_o` are all low and no fault is recorded. When the enable returns high on a healthy, fault-free supply, all four resume.
- R4: An undervoltage flag on the switching channel, once that channel's soft-start is done, turns off all three gate enables and latches code 2'b10. The same flag on the linear channel, once its soft-start is done, does the same and latches code 2'b11.
- R5: An undervoltage flag whose channel soft-start done input is low has no effect: the outputs keep running and the code stays 2'b00.
- R6: The overcurrent flag turns off all three gate enables and latches code 2'b01.
- R7: When several fault flags are seen in the same cycle, the code recorded is chosen in this order: overcurrent, then switching undervoltage, then linear undervoltage. A latched code is held unchanged while later flags arrive or go away.
- R8: A latched fault keeps all outputs off through any toggling of the enable. The falling-supply flag clears the code to 2'b00 and clears supply-good, so a new rising flag is needed before the outputs restart.
- R9: `hs_en_o` and `ls_en_o` are never high together. While running, `hs_en_o` follows `pwm_i` and `ls_en_o` follows its inverse.
- R10: If a fault flag and the falling-supply flag are seen in the same cycle, the supply drop wins and the code stays 2'b00.
- R11: All gate enables go low in the same cycle that the synchronized fault is seen. The code appears one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_rise_i | input | 1 | Supply above rising threshold (asynchronous) |
| sup_fall_i | input | 1 | Supply below falling threshold (asynchronous) |
| uv_sw_i | input | 1 | Switching feedback below half reference (asynchronous) |
| uv_lin_i | input | 1 | Linear feedback below half reference (asynchronous) |
| oc_i | input | 1 | Low-side switch drop above limit (asynchronous) |
| en_i | input | 1 | External enable, high to run (asynchronous) |
| ss_sw_done_i | input | 1 | Switching-channel soft-start finished |
| ss_lin_done_i | input | 1 | Linear-channel soft-start finished |
| pwm_i | input | 1 | Modulator phase request: 1 high-side on, 0 low-side on |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| lin_en_o | output | 1 | Linear pass-device enable |
| ss_run_o | output | 1 | Soft-start sequencer may ramp |
| fault_code_o | output | 2 | Latched fault: 00 none, 01 overcurrent, 10 switching UV, 11 linear UV |

## Verification
Two functions can fall in the same cycle. Fault capture can coincide with another fault flag, or with the supply-drop clear. The bench sweeps all 32 combinations of the three fault flags and the two soft-start done inputs, all raised on one edge, and computes the expected code from the priority order. It then raises overcurrent and the falling-supply flag on the same edge and expects the code to stay 00 with the outputs off. Gate outputs are sampled after exactly two edges and the code after three, which places the shutdown and the latch in their own cycles.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_OVCUR  = 2'b01,
    FLT_UV_SW  = 2'b10,
    FLT_UV_LIN = 2'b11
  } fault_e;

  localparam int NUM_ASYNC = 6;
  localparam int IDX_RISE  = 0;
  localparam int IDX_FALL  = 1;
  localparam int IDX_UVSW  = 2;
  localparam int IDX_UVLIN = 3;
  localparam int IDX_OC    = 4;
  localparam int IDX_EN    = 5;
endpackage

// File: rtl/rfs_sync.sv
module rfs_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rfs_supply.sv
module rfs_supply (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_s,
  input  logic fall_s,
  output logic supply_ok_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      supply_ok_o <= 1'b0;
    else if (fall_s) supply_ok_o <= 1'b0;
    else if (rise_s) supply_ok_o <= 1'b1;
  end

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok_o && !rise_s) |=> !supply_ok_o); // R2
endmodule

// File: rtl/rfs_fault_latch.sv
module rfs_fault_latch
  import rfs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   active_i,
  input  logic   fall_s,
  input  logic   oc_s,
  input  logic   uv_sw_s,
  input  logic   uv_lin_s,
  input  logic   sw_done_i,
  input  logic   lin_done_i,
  output fault_e fault_q_o,
  output logic   trip_o
);
  fault_e trip_code;

  always_comb begin
    trip_code = FLT_NONE;
    if (active_i && fault_q_o == FLT_NONE) begin
      if (oc_s)                         trip_code = FLT_OVCUR;
      else if (uv_sw_s && sw_done_i)    trip_code = FLT_UV_SW;
      else if (uv_lin_s && lin_done_i)  trip_code = FLT_UV_LIN;
    end
  end

  assign trip_o = (trip_code != FLT_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fault_q_o <= FLT_NONE;
    else if (fall_s) fault_q_o <= FLT_NONE;
    else if (trip_o) fault_q_o <= trip_code;
  end

  AST_CLEAR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    fall_s |=> (fault_q_o == FLT_NONE)); // R8
  AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q_o != FLT_NONE && !fall_s) |=> $stable(fault_q_o)); // R7
endmodule

// File: rtl/rfs_gate_ctrl.sv
module rfs_gate_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic fall_s,
  input  logic en_s,
  input  logic latched_i,
  input  logic trip_i,
  input  logic pwm_i,
  output logic hs_en_o,
  output logic ls_en_o,
  output logic lin_en_o,
  output logic ss_run_o
);
  logic permit;
  logic run;

  assign permit   = supply_ok_i && !fall_s && en_s && !latched_i;
  assign run      = permit && !trip_i;
  assign hs_en_o  = run && pwm_i;
  assign ls_en_o  = run && !pwm_i;
  assign lin_en_o = run;
  assign ss_run_o = permit;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en_o && ls_en_o)); // R9
  AST_OFF_WHEN_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    latched_i |-> (!hs_en_o && !ls_en_o && !lin_en_o)); // R4
endmodule

// File: rtl/reg_fault_supervisor.sv
module reg_fault_supervisor
  import rfs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sup_rise_i,
  input  logic       sup_fall_i,
  input  logic       uv_sw_i,
  input  logic       uv_lin_i,
  input  logic       oc_i,
  input  logic       en_i,
  input  logic       ss_sw_done_i,
  input  logic       ss_lin_done_i,
  input  logic       pwm_i,
  output logic       hs_en_o,
  output logic       ls_en_o,
  output logic       lin_en_o,
  output logic       ss_run_o,
  output logic [1:0] fault_code_o
);
  logic [NUM_ASYNC-1:0] raw_flags;
  logic [NUM_ASYNC-1:0] syn_flags;
  logic   supply_ok;
  logic   trip;
  fault_e fault_q;

  always_comb begin
    raw_flags            = '0;
    raw_flags[IDX_RISE]  = sup_rise_i;
    raw_flags[IDX_FALL]  = sup_fall_i;
    raw_flags[IDX_UVSW]  = uv_sw_i;
    raw_flags[IDX_UVLIN] = uv_lin_i;
    raw_flags[IDX_OC]    = oc_i;
    raw_flags[IDX_EN]    = en_i;
  end

  rfs_sync #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_flags), .q_o(syn_flags)
  );

  rfs_supply u_supply (
    .clk(clk), .rst_n(rst_n),
    .rise_s(syn_flags[IDX_RISE]), .fall_s(syn_flags[IDX_FALL]),
    .supply_ok_o(supply_ok)
  );

  rfs_fault_latch u_latch (
    .clk(clk), .rst_n(rst_n),
    .active_i(supply_ok && syn_flags[IDX_EN]),
    .fall_s(syn_flags[IDX_FALL]),
    .oc_s(syn_flags[IDX_OC]),
    .uv_sw_s(syn_flags[IDX_UVSW]),
    .uv_lin_s(syn_flags[IDX_UVLIN]),
    .sw_done_i(ss_sw_done_i),
    .lin_done_i(ss_lin_done_i),
    .fault_q_o(fault_q),
    .trip_o(trip)
  );

  rfs_gate_ctrl u_gate (
    .clk(clk), .rst_n(rst_n),
    .supply_ok_i(supply_ok),
    .fall_s(syn_flags[IDX_FALL]),
    .en_s(syn_flags[IDX_EN]),
    .latched_i(fault_q != FLT_NONE),
    .trip_i(trip),
    .pwm_i(pwm_i),
    .hs_en_o(hs_en_o),
    .ls_en_o(ls_en_o),
    .lin_en_o(lin_en_o),
    .ss_run_o(ss_run_o)
  );

  assign fault_code_o = fault_q;

  AST_CODE_MEANS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code_o != 2'b00) |-> (!hs_en_o && !ls_en_o && !lin_en_o && !ss_run_o)); // R11
endmodule

// File: tb/tb_reg_fault_supervisor.sv
module tb_reg_fault_supervisor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_rise = 0, sup_fall = 0, uv_sw = 0, uv_lin = 0, oc = 0, en = 0;
  logic sd_sw = 0, sd_lin = 0, pwm = 1;
  logic hs, ls, lin, ssr;
  logic [1:0] code;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  reg_fault_supervisor dut (
    .clk(clk), .rst_n(rst_n), .sup_rise_i(sup_rise), .sup_fall_i(sup_fall),
    .uv_sw_i(uv_sw), .uv_lin_i(uv_lin), .oc_i(oc), .en_i(en),
    .ss_sw_done_i(sd_sw), .ss_lin_done_i(sd_lin), .pwm_i(pwm),
    .hs_en_o(hs), .ls_en_o(ls), .lin_en_o(lin), .ss_run_o(ssr),
    .fault_code_o(code)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int gates_run(input logic p);
    return {29'd0, p, ~p, 1'b1};
  endfunction

  task automatic power_up();
    sup_fall = 0; sup_rise = 1; en = 1;
    edges(3);
    sup_rise = 0;
    edges(3);
  endtask

  task automatic power_drop();
    sup_fall = 1; edges(3);
    chk("R8 clear", code, 0);
    sup_fall = 0; edges(3);
    chk("R8 needs rise", {hs, ls, lin}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    edges(2);
    rst_n = 1;
    edges(1);
    chk("reset code", code, 0);
    chk("reset gates", {hs, ls, lin, ssr}, 0);
    // R2: enable without supply rise keeps everything off
    en = 1; edges(4);
    chk("R2 no rise", {hs, ls, lin, ssr}, 0);
    power_up();
    chk("R2 held after rise drop", {hs, ls, lin}, gates_run(1));
    // R9: pwm steering
    for (int k = 0; k < 4; k++) begin
      pwm = k[0];
      edges(1);
      chk("R9 steer", {hs, ls, lin}, gates_run(pwm));
    end
    pwm = 1;
    // R3 and R1 on enable
    en = 0; edges(1);
    chk("R1 en one edge", {hs, ls, lin}, gates_run(1));
    edges(1);
    chk("R3 en low", {hs, ls, lin, ssr}, 0);
    chk("R3 no fault", code, 0);
    en = 1; edges(2);
    chk("R3 resume", {hs, ls, lin, ssr}, {gates_run(1), 1'b1});
    // R10: overcurrent with supply drop
    oc = 1; sup_fall = 1; edges(2);
    chk("R10 gates off", {hs, ls, lin}, 0);
    edges(1);
    chk("R10 fall wins", code, 0);
    oc = 0; sup_fall = 0; edges(3);
    // sweep of fault flags and soft-start masks
    for (int c = 0; c < 32; c++) begin
      logic [4:0] v;
      int exp_code;
      v = c[4:0];
      sd_sw = v[3]; sd_lin = v[4];
      power_up();
      exp_code = v[0] ? 1 : (v[1] && v[3]) ? 2 : (v[2] && v[4]) ? 3 : 0;
      oc = v[0]; uv_sw = v[1]; uv_lin = v[2];
      edges(1);
      chk("R1 latency", {hs, ls, lin}, gates_run(1));
      edges(1);
      chk(exp_code == 0 ? "R5 masked run" : "R11 same-cycle off", {hs, ls, lin},
          exp_code == 0 ? gates_run(1) : 0);
      chk("R11 code not yet", code, 0);
      edges(1);
      chk(exp_code == 1 ? "R6 oc code" : exp_code == 0 ? "R5 code" : "R4 uv code R7",
          code, exp_code);
      oc = 0; uv_sw = 0; uv_lin = 0;
      if (exp_code != 0) begin
        uv_lin = 1; sd_lin = 1; edges(4);
        chk("R7 held", code, exp_code);
        uv_lin = 0;
        en = 0; edges(3); en = 1; edges(4);
        chk("R8 en ignored code", code, exp_code);
        chk("R8 en ignored gates", {hs, ls, lin, ssr}, 0);
      end
      power_drop();
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule